// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the host side of a four-wire synchronous serial link to an eight-channel, 12-bit converter that runs from the host's serial clock. A conversion request carries a channel number, two input-mode bits and a two-bit power field. The block drives chip select and the serial clock and shifts out an 8-bit control byte. It then captures the 12-bit result and presents it on a result word with a one-cycle valid strobe. The serial clock runs at the system clock divided by an even number, set by the parameter `HALF_DIV` (system clocks per half period). Data leaves on falling edges and the result is sampled on rising edges.

Two framings are offered, chosen by the `frame16` input at the start of each burst. In the compact framing, a waiting request's control byte begins on the 16th serial clock of the current conversion, while that conversion's last result bits are still arriving. In continuous operation this gives 15 clocks per conversion. In the byte-aligned framing, the next control byte begins on the 17th clock, and a burst's final conversion is padded to 24 clocks. A request that arrives while the link is busy is held in a one-entry slot and issued at the next opportunity.

Top module: `adc_link_seq`

## Requirements
- R1: After reset and between bursts, cs_n is high, sclk is low, mosi is low, busy is low and rvalid is low. sclk never goes high while cs_n is high.
- R2: Each control byte is shifted MSB first as {1, chan[2:0], uni, sgl, pd[1:0]}: the start bit is bit 7, the channel is bits 6:4, uni is bit 3, sgl is bit 2 and the power field is bits 1:0. mosi changes only on falling sclk edges, and the start bit is on mosi from the moment cs_n falls.
- R3: The result is taken from miso on the 10th to 21st rising edges of a conversion, counted from the rising edge that samples its start bit. The first of these bits is bit 11, and the 12 bits together form rdata.
- R4: rvalid is high for exactly one system clock, in the cycle after the edge that captures the 12th bit. rdata keeps that value until the next result.
- R5: A burst with a single conversion has 21 rising sclk edges in compact framing (frame16=0) and 24 in byte-aligned framing (frame16=1).
- R6: In compact framing, a pending request's start bit is sampled on rising edge 16 of the running conversion. A burst of n conversions has 15(n-1)+21 rising edges.
- R7: In byte-aligned framing, a pending request's start bit is sampled on rising edge 17. A burst of n conversions has 16(n-1)+24 rising edges.
- R8: mosi is low whenever cs_n is high. Inside a burst, mosi is high only for the 1 bits of control bytes.
- R9: Every high phase and every low phase of sclk inside a burst lasts HALF_DIV system clocks.
- R10: cs_n falls HALF_DIV system clocks before the first rising sclk edge. It rises HALF_DIV system clocks after the last falling edge.
- R11: busy is high from the cycle after an accepted request until the burst that serves it ends. A request made while busy is held. A request made while one is already held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Conversion request, one-cycle pulse |
| req_chan | input | 3 | Channel number placed in the control byte |
| req_uni | input | 1 | Input-mode bit (unipolar select) |
| req_sgl | input | 1 | Input-mode bit (single-ended select) |
| req_pd | input | 2 | Power/clock field placed in the last two control bits |
| frame16 | input | 1 | 1 selects byte-aligned 16-clock framing, 0 compact 15-clock framing |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| rdata | output | 12 | Last captured result |
| rvalid | output | 1 | One-cycle strobe for a new rdata |
| busy | output | 1 | Request held or burst in progress |

## Verification
The bench uses a behavioural converter that waits for the first 1 on mosi, collects the byte and returns a result derived from that byte and its sequence number. A table of single conversions varies channel, mode bits, power field and framing. This shows that each field lands in its own bit position and that both framings end a lone conversion at the right edge count. A three-conversion compact burst and a two-conversion byte-aligned burst tell true overlap apart from serialised frames, through the edge count per burst and the result order. A triple request that arrives while busy shows that the held slot keeps the second request and drops the third.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    localparam int CTRL_W    = 8;
    localparam int RES_W     = 12;
    localparam int CHAN_W    = 3;
    localparam int EDGE_W    = 5;
    localparam int RES_FIRST = 9;
    localparam int RES_LAST  = RES_FIRST + RES_W - 1;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_TAIL
    } seq_state_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              uni;
        logic              sgl;
        logic [1:0]        pd;
    } conv_req_t;

    function automatic logic [CTRL_W-1:0] ctrl_byte(input conv_req_t r);
        return {1'b1, r.chan, r.uni, r.sgl, r.pd};
    endfunction

    function automatic logic [EDGE_W-1:0] frame_period(input logic wide);
        return wide ? EDGE_W'(16) : EDGE_W'(15);
    endfunction

    function automatic logic [EDGE_W-1:0] burst_end(input logic wide);
        return wide ? EDGE_W'(24) : EDGE_W'(RES_LAST + 1);
    endfunction

endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF_DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(HALF_DIV - 1));
endmodule

// File: rtl/adc_tx_shift.sv
module adc_tx_shift
    import adc_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CTRL_W-1:0] load_byte,
    input  logic              shift,
    output logic              sdo
);
    localparam int LW = $clog2(CTRL_W);

    logic [CTRL_W-1:0] sr;
    logic [LW-1:0]     left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            left <= '0;
            sdo  <= 1'b0;
        end else if (load) begin
            sr   <= {load_byte[CTRL_W-2:0], 1'b0};
            left <= LW'(CTRL_W - 1);
            sdo  <= load_byte[CTRL_W-1];
        end else if (shift) begin
            if (left != '0) begin
                sdo  <= sr[CTRL_W-1];
                sr   <= {sr[CTRL_W-2:0], 1'b0};
                left <= left - 1'b1;
            end else begin
                sdo <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift
    import adc_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             last,
    input  logic             sdi,
    output logic [RES_W-1:0] word
);
    logic [RES_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            word <= '0;
        end else if (cap) begin
            sr <= {sr[RES_W-2:0], sdi};
            if (last) begin
                word <= {sr[RES_W-2:0], sdi};
            end
        end
    end
endmodule

// File: rtl/adc_link_seq.sv
module adc_link_seq
    import adc_link_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_uni,
    input  logic              req_sgl,
    input  logic [1:0]        req_pd,
    input  logic              frame16,
    input  logic              miso,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic [RES_W-1:0]  rdata,
    output logic              rvalid,
    output logic              busy
);
    seq_state_t        st;
    conv_req_t         held;
    logic              pend;
    logic              wide;
    logic              nxt;
    logic [EDGE_W-1:0] t;
    logic              tick;
    logic              rise_ev, fall_ev;
    logic              launch_first, launch_next;
    logic              cap, cap_last;
    logic [EDGE_W-1:0] per, fin;

    assign per          = frame_period(wide);
    assign fin          = burst_end(wide);
    assign rise_ev      = (st == SEQ_RUN) && tick && !sclk;
    assign fall_ev      = (st == SEQ_RUN) && tick && sclk;
    assign launch_first = (st == SEQ_IDLE) && pend;
    assign launch_next  = fall_ev && (t == per) && !nxt && pend;
    assign cap          = rise_ev && (t >= EDGE_W'(RES_FIRST)) && (t <= EDGE_W'(RES_LAST));
    assign cap_last     = rise_ev && (t == EDGE_W'(RES_LAST));
    assign busy         = (st != SEQ_IDLE) || pend;

    adc_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (st != SEQ_IDLE),
        .tick (tick)
    );

    adc_tx_shift u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (launch_first || launch_next),
        .load_byte (ctrl_byte(held)),
        .shift     (fall_ev && !launch_next),
        .sdo       (mosi)
    );

    adc_rx_shift u_rx (
        .clk  (clk),
        .rst  (rst),
        .cap  (cap),
        .last (cap_last),
        .sdi  (miso),
        .word (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SEQ_IDLE;
            held   <= '0;
            pend   <= 1'b0;
            wide   <= 1'b0;
            nxt    <= 1'b0;
            t      <= '0;
            cs_n   <= 1'b1;
            sclk   <= 1'b0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= cap_last;
            if (req && !pend) begin
                pend <= 1'b1;
                held <= '{chan: req_chan, uni: req_uni, sgl: req_sgl, pd: req_pd};
            end
            unique case (st)
                SEQ_IDLE: begin
                    if (pend) begin
                        st   <= SEQ_RUN;
                        cs_n <= 1'b0;
                        wide <= frame16;
                        t    <= '0;
                        nxt  <= 1'b0;
                        pend <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (rise_ev) begin
                        sclk <= 1'b1;
                        if (cap_last && nxt) begin
                            t   <= EDGE_W'(RES_LAST + 1) - per;
                            nxt <= 1'b0;
                        end else begin
                            t <= t + 1'b1;
                        end
                    end else if (fall_ev) begin
                        sclk <= 1'b0;
                        if (launch_next) begin
                            nxt  <= 1'b1;
                            pend <= 1'b0;
                        end else if (!nxt && t == fin) begin
                            st <= SEQ_TAIL;
                        end
                    end
                end
                SEQ_TAIL: begin
                    if (tick) begin
                        st   <= SEQ_IDLE;
                        cs_n <= 1'b1;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_link_chk.sv
module adc_link_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic rvalid
);
    assert_sclk_parked_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_start_with_select_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> mosi);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    assert_line_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !mosi);

    assert_busy_covers_burst_R11: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);
endmodule

bind adc_link_seq adc_link_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .mosi   (mosi),
    .busy   (busy),
    .rvalid (rvalid)
);

// File: tb/sim_adc_link_seq.sv
module sim_adc_link_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HDIV       = 3;
    localparam int WD_LIMIT   = 150000;

    // vector: [15:13] chan, [12] uni, [11] sgl, [10:9] pd, [8] frame16, [7:0] rising edges
    localparam logic [15:0] VEC [6] = '{
        {3'd0, 1'b1, 1'b1, 2'b11, 1'b0, 8'd21},
        {3'd7, 1'b0, 1'b1, 2'b11, 1'b1, 8'd24},
        {3'd5, 1'b1, 1'b0, 2'b11, 1'b0, 8'd21},
        {3'd2, 1'b0, 1'b0, 2'b11, 1'b1, 8'd24},
        {3'd6, 1'b1, 1'b1, 2'b10, 1'b0, 8'd21},
        {3'd1, 1'b0, 1'b1, 2'b00, 1'b1, 8'd24}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  req_chan = '0;
    logic        req_uni = 1'b0;
    logic        req_sgl = 1'b0;
    logic [1:0]  req_pd = '0;
    logic        frame16 = 1'b0;
    logic        miso = 1'b0;
    logic        cs_n, sclk, mosi, rvalid, busy;
    logic [11:0] rdata;

    adc_link_seq #(.HALF_DIV(HDIV)) u0 (
        .clk(clk), .rst(rst), .req(req), .req_chan(req_chan), .req_uni(req_uni),
        .req_sgl(req_sgl), .req_pd(req_pd), .frame16(frame16), .miso(miso),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .rdata(rdata), .rvalid(rvalid), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int rv_chk = 0, rv_fail = 0;
    int exp_ones = 0;

    // behavioural converter
    int          rx_cnt = 0, nbytes = 0, done_cnt = 0, seen = 0, ocnt = 0;
    logic [7:0]  rx_sr = '0;
    logic [7:0]  log_byte [0:63];
    logic [11:0] exp_res [0:63];
    logic [11:0] val_next = '0, osr = '0;

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (rx_cnt == 0) begin
                if (mosi) begin
                    rx_sr  = 8'h01;
                    rx_cnt = 1;
                end
            end else begin
                rx_sr  = {rx_sr[6:0], mosi};
                rx_cnt = rx_cnt + 1;
                if (rx_cnt == 8) begin
                    log_byte[nbytes] = rx_sr;
                    val_next         = {rx_sr, 4'(nbytes)} ^ 12'h6C9;
                    exp_res[nbytes]  = val_next;
                    nbytes           = nbytes + 1;
                    done_cnt         = done_cnt + 1;
                    rx_cnt           = 0;
                end
            end
        end
    end

    always @(negedge sclk) begin
        if (seen != done_cnt) begin
            seen = done_cnt;
            osr  = val_next;
            ocnt = 1;
            miso = 1'b0;
        end else if (ocnt >= 1 && ocnt <= 12) begin
            miso = osr[12-ocnt];
            ocnt = ocnt + 1;
        end else begin
            miso = 1'b0;
            ocnt = 0;
        end
    end

    // port monitor
    logic prev_s = 1'b0, prev_cs = 1'b1, prev_rv = 1'b0;
    int burst_rises = 0, last_rises = 0, last_trail = 0;
    int low_run = 0, high_run = 0, bad_phase = 0, ones_rise = 0;
    int quiet_bad = 0, nres = 0, dbl_pulse = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n) begin
                if (sclk && !prev_s) begin
                    burst_rises = burst_rises + 1;
                    if (low_run != HDIV) bad_phase = bad_phase + 1;
                    low_run  = 0;
                    high_run = 1;
                    if (mosi) ones_rise = ones_rise + 1;
                end else if (sclk) begin
                    high_run = high_run + 1;
                end else if (prev_s) begin
                    if (high_run != HDIV) bad_phase = bad_phase + 1;
                    low_run = 1;
                end else begin
                    low_run = low_run + 1;
                end
            end else begin
                if (!prev_cs) begin
                    last_rises = burst_rises;
                    last_trail = low_run;
                end
                burst_rises = 0;
                low_run     = 0;
                high_run    = 0;
                if (mosi || sclk) quiet_bad = quiet_bad + 1;
            end
            if (rvalid) begin
                rv_chk = rv_chk + 1;
                if (rdata !== exp_res[nres]) begin
                    rv_fail = rv_fail + 1;
                    $display("FAIL R3 result word actual=%0h expected=%0h", rdata, exp_res[nres]);
                end
                nres = nres + 1;
            end
            if (rvalid && prev_rv) dbl_pulse = dbl_pulse + 1;
            prev_s  = sclk;
            prev_cs = cs_n;
            prev_rv = rvalid;
        end
    end

    function automatic void report(input int extra_fail);
        int tot, bad;
        tot = n_chk + rv_chk + extra_fail;
        bad = n_fail + rv_fail + extra_fail;
        $display("%0d/%0d checks passed", tot - bad, tot);
    endfunction

    int cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_LIMIT) begin
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, WD_LIMIT);
            report(1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] cbyte(input logic [2:0] c, input logic u, input logic s,
                                         input logic [1:0] p);
        return {1'b1, c, u, s, p};
    endfunction

    task automatic issue(input logic [2:0] c, input logic u, input logic s, input logic [1:0] p);
        @(negedge clk);
        req = 1'b1; req_chan = c; req_uni = u; req_sgl = s; req_pd = p;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || !cs_n);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int b0, r0;
        logic [7:0] ea, eb, ec;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(cs_n && !sclk && !mosi && !busy && !rvalid, "R1 outputs in reset",
            {cs_n, sclk, mosi, busy, rvalid}, 5'b10000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !mosi && !busy && !rvalid, "R1 idle after reset",
            {cs_n, sclk, mosi, busy, rvalid}, 5'b10000);

        for (int i = 0; i < 6; i++) begin
            logic [15:0] v;
            logic [7:0]  eb_v;
            v = VEC[i];
            frame16 = v[8];
            b0 = nbytes; r0 = nres;
            eb_v = cbyte(v[15:13], v[12], v[11], v[10:9]);
            exp_ones = exp_ones + $countones(eb_v);
            issue(v[15:13], v[12], v[11], v[10:9]);
            wait_idle();
            chk(nbytes == b0 + 1, "R2 one control byte per request", nbytes - b0, 1);
            chk(log_byte[b0] == eb_v, "R2 control byte fields", log_byte[b0], eb_v);
            chk(nres == r0 + 1, "R4 one strobe per conversion", nres - r0, 1);
            chk(rdata == exp_res[b0], "R4 rdata held after strobe", rdata, exp_res[b0]);
            chk(last_rises == int'(v[7:0]), "R5 edges for single conversion", last_rises, v[7:0]);
            chk(last_trail == HDIV, "R10 trailing half period", last_trail, HDIV);
        end

        // R6: three pipelined conversions in compact framing
        frame16 = 1'b0;
        b0 = nbytes; r0 = nres;
        ea = cbyte(3'd3, 1'b1, 1'b1, 2'b11);
        eb = cbyte(3'd4, 1'b0, 1'b1, 2'b11);
        ec = cbyte(3'd6, 1'b1, 1'b0, 2'b11);
        exp_ones = exp_ones + $countones(ea) + $countones(eb) + $countones(ec);
        issue(3'd3, 1'b1, 1'b1, 2'b11);
        repeat (3) @(negedge clk);
        issue(3'd4, 1'b0, 1'b1, 2'b11);
        while (nres < r0 + 1) @(negedge clk);
        issue(3'd6, 1'b1, 1'b0, 2'b11);
        wait_idle();
        chk(last_rises == 2*15 + 21, "R6 edges for three overlapped conversions", last_rises, 51);
        chk(nbytes == b0 + 3, "R6 bytes in burst", nbytes - b0, 3);
        chk(log_byte[b0] == ea && log_byte[b0+1] == eb && log_byte[b0+2] == ec,
            "R6 byte order", log_byte[b0+2], ec);
        chk(nres == r0 + 3, "R6 results in burst", nres - r0, 3);

        // R7: two conversions in byte-aligned framing
        frame16 = 1'b1;
        b0 = nbytes; r0 = nres;
        ea = cbyte(3'd1, 1'b1, 1'b1, 2'b11);
        eb = cbyte(3'd7, 1'b0, 1'b0, 2'b11);
        exp_ones = exp_ones + $countones(ea) + $countones(eb);
        issue(3'd1, 1'b1, 1'b1, 2'b11);
        repeat (3) @(negedge clk);
        issue(3'd7, 1'b0, 1'b0, 2'b11);
        wait_idle();
        chk(last_rises == 16 + 24, "R7 edges for two aligned conversions", last_rises, 40);
        chk(nbytes == b0 + 2 && log_byte[b0+1] == eb, "R7 second byte", log_byte[b0+1], eb);
        chk(nres == r0 + 2, "R7 results in burst", nres - r0, 2);

        // R11: held request kept, third dropped
        frame16 = 1'b0;
        b0 = nbytes;
        ea = cbyte(3'd2, 1'b0, 1'b1, 2'b11);
        eb = cbyte(3'd5, 1'b1, 1'b1, 2'b11);
        exp_ones = exp_ones + $countones(ea) + $countones(eb);
        issue(3'd2, 1'b0, 1'b1, 2'b11);
        chk(busy == 1'b1, "R11 busy after accepted request", busy, 1);
        repeat (2) @(negedge clk);
        issue(3'd5, 1'b1, 1'b1, 2'b11);
        issue(3'd0, 1'b0, 1'b0, 2'b00);
        wait_idle();
        chk(nbytes == b0 + 2, "R11 request while held dropped", nbytes - b0, 2);
        chk(log_byte[b0+1] == eb, "R11 held request served", log_byte[b0+1], eb);
        chk(last_rises == 15 + 21, "R11 held request overlapped", last_rises, 36);
        chk(!busy && cs_n, "R11 busy clear after burst", busy, 0);

        chk(quiet_bad == 0, "R8 mosi and sclk low while deselected", quiet_bad, 0);
        chk(ones_rise == exp_ones, "R8 mosi high only for control bits", ones_rise, exp_ones);
        chk(bad_phase == 0, "R9 and R10 half period lengths", bad_phase, 0);
        chk(dbl_pulse == 0, "R4 strobe single cycle", dbl_pulse, 0);

        report(0);
        $finish;
    end
endmodule